// File: doc/BRIEF.md
# Stop-State Entry and Wake Controller

This block puts a small microcontroller core into a low-power stop state and brings it back out. Software writes an 8-bit control register. One bit asks for stop. One bit chooses how the stop is released. One bit chooses what the port pins do while the core is halted.

On entry the block gates the oscillator off and pulses a prescaler clear. It freezes the port output latches, and it either keeps driving them or floats them. An external wake pin, passed through a two-flop synchronizer, ends the stop state. The wake can be taken from the pin's high level or from its rising edge only. Before the core clock returns, a warm-up counter runs for a fixed number of cycles so the oscillator can settle. When normal operation resumes, the stop-request bit clears and a one-cycle done strobe fires.

The CPU, the interrupt controller, the oscillator and the pads are not modelled. The block only produces enable, clear and strobe signals for them.

Top module: `srcu_stop_ctrl`

## Requirements
- R1: After reset the state is NORMAL and `osc_en` and `core_clk_en` are 1. `cfg_rdata` is 0, `port_out` is 0 and every `port_oe` bit is 1.
- R2: A write in NORMAL with bit 7 set moves the block to STOP at that clock edge when the effective release mode is edge (bit 6 = 0). In STOP, `osc_en` and `core_clk_en` are 0. `presc_clr` is high for exactly the first STOP cycle.
- R3: Outside NORMAL, `port_out` keeps the value latched last and `port_latch_wr` has no effect. `port_oe` is all ones when the register's bit 4 is 1 and all zeros when bit 4 is 0. In NORMAL, `port_oe` is all ones.
- R4: With edge release in effect, STOP is left only on a rising edge of the synchronized pin. A pin held high does not release it. The state shows WARMUP three clock edges after the pin rises.
- R5: With level release in effect (bit 6 = 1), STOP is left whenever the synchronized pin is high. The state shows WARMUP three clock edges after the pin goes high.
- R6: With level release in effect, a stop request made while the synchronized pin is high goes straight to WARMUP. STOP is skipped, `presc_clr` stays 0 and `osc_en` stays 1.
- R7: WARMUP lasts exactly WARM_LEN cycles. During it `osc_en` is 1 and `core_clk_en` is 0, and a low pin never sends the block back to STOP.
- R8: When WARMUP ends, the state becomes NORMAL and `core_clk_en` is 1. `cfg_rdata[7]` reads 0. `wake_done` is 1 for exactly that first NORMAL cycle.
- R9: `cfg_rdata[6]` shows the release mode in effect. Writing bit 6 = 1 while edge release is in effect leaves edge release active until the next rising edge of the synchronized pin. Writing bit 6 = 0 selects edge release at once.
- R10: Register writes are ignored while the state is STOP or WARMUP.
- R11: `state_o` encodes NORMAL as 2'b00, STOP as 2'b01 and WARMUP as 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Write data: bit 7 stop request, bit 6 release mode, bit 4 hold-drive |
| cfg_rdata | output | 8 | Register read-back: bit 7 stop request, bit 6 effective release mode, bit 4 hold-drive |
| wake_pin | input | 1 | Asynchronous stop/wake pin |
| port_latch_wr | input | 1 | Core write strobe for the port output latches |
| port_latch_din | input | PORT_W | Data written to the port latches |
| port_out | output | PORT_W | Port latch outputs |
| port_oe | output | PORT_W | Port drive enables, 0 = high impedance |
| osc_en | output | 1 | Oscillator enable |
| core_clk_en | output | 1 | Core clock enable |
| presc_clr | output | 1 | Prescaler clear pulse |
| state_o | output | 2 | Current controller state |
| wake_done | output | 1 | One-cycle strobe when NORMAL resumes |

## Verification
Two events can fall on the same clock edge, and the bench provokes both.

The first is a rising pin edge that arrives while a switch to level release is pending. That one edge must both release STOP and promote the pending mode. The bench first requests stop with the pin already high. It then checks that the block still stops under edge rules, and that a single later rising edge both ends STOP and flips `cfg_rdata[6]`.

The second is the stop request itself under level release. Here the request and the release decision coincide. The sweep over release mode, hold-drive and pin level at request time expects a direct jump to WARMUP with no prescaler clear, and measures WARMUP's exact length.

// File: rtl/srcu_pkg.sv
package srcu_pkg;

    typedef enum logic [1:0] {
        ST_NORMAL = 2'b00,
        ST_STOP   = 2'b01,
        ST_WARMUP = 2'b10
    } srcu_state_e;

    localparam int unsigned CFG_W    = 8;
    localparam int unsigned BIT_STOP = 7;
    localparam int unsigned BIT_RELM = 6;
    localparam int unsigned BIT_HOLD = 4;

    typedef struct packed {
        srcu_state_e state;
        logic        stop_req;
        logic        relm_eff;
        logic        relm_pend;
        logic        hold_drv;
        logic        presc_clr;
        logic        wake_done;
    } srcu_ctl_t;

endpackage

// File: rtl/srcu_pin_sync.sv
module srcu_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_lvl,
    output logic pin_rise
);
    typedef struct packed {
        logic meta;
        logic lvl;
        logic prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.meta = pin_async;
        s_d.lvl  = s_q.meta;
        s_d.prev = s_q.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pin_lvl  = s_q.lvl;
    assign pin_rise = s_q.lvl & ~s_q.prev;

    // R4
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_rise |=> !pin_rise);

endmodule

// File: rtl/srcu_warm_cnt.sv
module srcu_warm_cnt #(
    parameter int unsigned WARM_LEN = 256,
    localparam int unsigned CNT_W   = (WARM_LEN < 2) ? 1 : $clog2(WARM_LEN)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic zero
);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WARM_LEN - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = LOAD_VAL;
        else if (run && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // R7
    cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && zero) |=> zero);

    // R7
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == LOAD_VAL));

endmodule

// File: rtl/srcu_port_hold.sv
module srcu_port_hold #(
    parameter int unsigned PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PORT_W-1:0] wr_data,
    input  logic              frozen,
    input  logic              hold_drv,
    output logic [PORT_W-1:0] port_out,
    output logic [PORT_W-1:0] port_oe
);
    logic [PORT_W-1:0] lat_d, lat_q;

    always_comb begin
        lat_d = lat_q;
        if (wr_en && !frozen)
            lat_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    assign port_out = lat_q;
    assign port_oe  = (!frozen || hold_drv) ? {PORT_W{1'b1}} : {PORT_W{1'b0}};

    // R3
    latch_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |=> $stable(lat_q));

endmodule

// File: rtl/srcu_stop_ctrl.sv
module srcu_stop_ctrl
    import srcu_pkg::*;
#(
    parameter int unsigned PORT_W   = 8,
    parameter int unsigned WARM_LEN = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              wake_pin,
    input  logic              port_latch_wr,
    input  logic [PORT_W-1:0] port_latch_din,
    output logic [PORT_W-1:0] port_out,
    output logic [PORT_W-1:0] port_oe,
    output logic              osc_en,
    output logic              core_clk_en,
    output logic              presc_clr,
    output logic [1:0]        state_o,
    output logic              wake_done
);
    srcu_ctl_t ctl_d, ctl_q;
    logic      pin_lvl, pin_rise, warm_zero, warm_load, warm_run;
    logic      unused_cfg_bits;

    assign unused_cfg_bits = ^{cfg_wdata[5], cfg_wdata[3:0]};

    srcu_pin_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_async(wake_pin),
        .pin_lvl  (pin_lvl),
        .pin_rise (pin_rise)
    );

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.presc_clr = 1'b0;
        ctl_d.wake_done = 1'b0;

        if (pin_rise && ctl_q.relm_pend) begin
            ctl_d.relm_eff  = 1'b1;
            ctl_d.relm_pend = 1'b0;
        end

        unique case (ctl_q.state)
            ST_NORMAL: begin
                if (cfg_we) begin
                    ctl_d.hold_drv = cfg_wdata[BIT_HOLD];
                    if (!cfg_wdata[BIT_RELM]) begin
                        ctl_d.relm_eff  = 1'b0;
                        ctl_d.relm_pend = 1'b0;
                    end else if (!ctl_d.relm_eff) begin
                        ctl_d.relm_pend = 1'b1;
                    end
                    if (cfg_wdata[BIT_STOP]) begin
                        ctl_d.stop_req = 1'b1;
                        if (ctl_d.relm_eff && pin_lvl) begin
                            ctl_d.state = ST_WARMUP;
                        end else begin
                            ctl_d.state     = ST_STOP;
                            ctl_d.presc_clr = 1'b1;
                        end
                    end
                end
            end
            ST_STOP: begin
                if ((ctl_q.relm_eff && pin_lvl) || pin_rise)
                    ctl_d.state = ST_WARMUP;
            end
            ST_WARMUP: begin
                if (warm_zero) begin
                    ctl_d.state     = ST_NORMAL;
                    ctl_d.stop_req  = 1'b0;
                    ctl_d.wake_done = 1'b1;
                end
            end
            default: ctl_d.state = ST_NORMAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_NORMAL;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign warm_load = (ctl_q.state != ST_WARMUP) && (ctl_d.state == ST_WARMUP);
    assign warm_run  = (ctl_q.state == ST_WARMUP);

    srcu_warm_cnt #(.WARM_LEN(WARM_LEN)) u_warm (
        .clk  (clk),
        .rst_n(rst_n),
        .load (warm_load),
        .run  (warm_run),
        .zero (warm_zero)
    );

    srcu_port_hold #(.PORT_W(PORT_W)) u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (port_latch_wr),
        .wr_data (port_latch_din),
        .frozen  (ctl_q.state != ST_NORMAL),
        .hold_drv(ctl_q.hold_drv),
        .port_out(port_out),
        .port_oe (port_oe)
    );

    assign cfg_rdata   = {ctl_q.stop_req, ctl_q.relm_eff, 1'b0, ctl_q.hold_drv, 4'b0000};
    assign osc_en      = (ctl_q.state != ST_STOP);
    assign core_clk_en = (ctl_q.state == ST_NORMAL);
    assign presc_clr   = ctl_q.presc_clr;
    assign state_o     = ctl_q.state;
    assign wake_done   = ctl_q.wake_done;

    // R2
    presc_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_NORMAL && ctl_d.state == ST_STOP) |=> presc_clr);

    // R4
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_STOP && !ctl_q.relm_eff && !pin_rise) |=> (ctl_q.state == ST_STOP));

    // R7
    warm_no_restop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_WARMUP) |=> (ctl_q.state != ST_STOP));

    // R8
    wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_WARMUP && warm_zero) |=> (wake_done && ctl_q.state == ST_NORMAL && !ctl_q.stop_req));

    // R10
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state != ST_NORMAL && ctl_d.state != ST_NORMAL) |=> $stable(ctl_q.hold_drv));

    // R11
    state_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_o != 2'b11);

endmodule

// File: tb/tb_srcu_stop_ctrl.sv
module tb_srcu_stop_ctrl;
    localparam int PW = 8;
    localparam int WL = 5;
    localparam logic [1:0] S_NORM = 2'b00;
    localparam logic [1:0] S_STOP = 2'b01;
    localparam logic [1:0] S_WARM = 2'b10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [7:0]    cfg_wdata = '0;
    logic [7:0]    cfg_rdata;
    logic          wake_pin = 1'b0;
    logic          port_latch_wr = 1'b0;
    logic [PW-1:0] port_latch_din = '0;
    logic [PW-1:0] port_out, port_oe;
    logic          osc_en, core_clk_en, presc_clr, wake_done;
    logic [1:0]    state_o;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    srcu_stop_ctrl #(.PORT_W(PW), .WARM_LEN(WL)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .wake_pin(wake_pin), .port_latch_wr(port_latch_wr),
        .port_latch_din(port_latch_din), .port_out(port_out), .port_oe(port_oe),
        .osc_en(osc_en), .core_clk_en(core_clk_en), .presc_clr(presc_clr),
        .state_o(state_o), .wake_done(wake_done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_cfg(input logic [7:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic wr_port(input logic [PW-1:0] v);
        port_latch_wr = 1'b1; port_latch_din = v;
        @(negedge clk);
        port_latch_wr = 1'b0;
    endtask

    // Called on the first WARMUP cycle; measures WARMUP and checks the return to NORMAL.
    task automatic finish_warm;
        int cyc = 0;
        wake_pin = 1'b0;
        while (state_o == S_WARM && cyc < 50) begin
            cyc++;
            chk(osc_en == 1'b1 && core_clk_en == 1'b0, "R7 warmup enables", {osc_en, core_clk_en}, 2);
            step(1);
        end
        chk(cyc == WL, "R7 warmup length", cyc, WL);
        chk(state_o == S_NORM, "R8 state after warmup (R11 NORMAL=00)", state_o, S_NORM);
        chk(wake_done == 1'b1, "R8 wake_done pulse", wake_done, 1);
        chk(core_clk_en == 1'b1, "R8 core clock back", core_clk_en, 1);
        chk(cfg_rdata[7] == 1'b0, "R8 stop bit self-clears", cfg_rdata[7], 0);
        chk(port_oe == '1, "R3 oe in NORMAL", port_oe, 255);
        step(1);
        chk(wake_done == 1'b0, "R8 wake_done one cycle", wake_done, 0);
    endtask

    task automatic run_case(input bit mode, input bit hold, input bit pin0);
        logic [PW-1:0] v;
        logic [7:0] req;
        bit skip;
        wr_cfg(8'h00);
        wake_pin = 1'b0;
        step(4);
        if (mode) begin
            wr_cfg(8'h40);
            wake_pin = 1'b1;
            step(4);
            chk(cfg_rdata[6] == 1'b1, "R9 level mode active after rise", cfg_rdata[6], 1);
        end
        wake_pin = pin0;
        step(4);
        v = 8'h5A ^ {5'b0, mode, hold, pin0};
        wr_port(v);
        chk(port_out == v, "R3 latch write in NORMAL", port_out, v);
        req = {1'b1, mode, 1'b0, hold, 4'b0};
        skip = mode && pin0;
        wr_cfg(req);
        if (skip) begin
            chk(state_o == S_WARM, "R6 skip to WARMUP (R11 WARMUP=10)", state_o, S_WARM);
            chk(presc_clr == 1'b0, "R6 no prescaler clear", presc_clr, 0);
            chk(osc_en == 1'b1, "R6 oscillator stays on", osc_en, 1);
            chk(port_oe == (hold ? 8'hFF : 8'h00), "R3 oe during warmup", port_oe, hold ? 255 : 0);
        end else begin
            chk(state_o == S_STOP, "R2 enter STOP (R11 STOP=01)", state_o, S_STOP);
            chk(presc_clr == 1'b1, "R2 prescaler clear", presc_clr, 1);
            chk(osc_en == 1'b0 && core_clk_en == 1'b0, "R2 clocks off", {osc_en, core_clk_en}, 0);
            step(1);
            chk(presc_clr == 1'b0, "R2 clear is one cycle", presc_clr, 0);
            chk(port_out == v, "R3 latch held", port_out, v);
            chk(port_oe == (hold ? 8'hFF : 8'h00), "R3 oe in STOP", port_oe, hold ? 255 : 0);
            wr_port(~v);
            chk(port_out == v, "R3 latch write ignored", port_out, v);
            wr_cfg(8'h00);
            chk(cfg_rdata == req, "R10 write ignored in STOP", cfg_rdata, req);
            chk(state_o == S_STOP, "R10 still STOP", state_o, S_STOP);
            if (!mode && pin0) begin
                step(6);
                chk(state_o == S_STOP, "R4 high level does not release", state_o, S_STOP);
                wake_pin = 1'b0;
                step(4);
                chk(state_o == S_STOP, "R4 low does not release", state_o, S_STOP);
            end
            wake_pin = 1'b1;
            step(2);
            chk(state_o == S_STOP, mode ? "R5 release latency" : "R4 release latency", state_o, S_STOP);
            step(1);
            chk(state_o == S_WARM, mode ? "R5 level release" : "R4 edge release", state_o, S_WARM);
        end
        finish_warm();
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        chk(state_o == S_NORM, "R1 reset state", state_o, S_NORM);
        chk(osc_en == 1'b1 && core_clk_en == 1'b1, "R1 clocks on", {osc_en, core_clk_en}, 3);
        chk(cfg_rdata == 8'h00, "R1 register clear", cfg_rdata, 0);
        chk(port_out == '0 && port_oe == '1, "R1 ports", port_oe, 255);

        for (int m = 0; m < 2; m++)
            for (int h = 0; h < 2; h++)
                for (int p = 0; p < 2; p++)
                    run_case(m[0], h[0], p[0]);

        // R9: pending switch to level mode, and same-edge release plus promotion
        wr_cfg(8'h00);
        wake_pin = 1'b1;
        step(4);
        wr_cfg(8'h40);
        chk(cfg_rdata[6] == 1'b0, "R9 switch held pending", cfg_rdata[6], 0);
        wr_cfg(8'hC0);
        chk(state_o == S_STOP, "R9 pending mode still edge at entry", state_o, S_STOP);
        wake_pin = 1'b0;
        step(4);
        chk(state_o == S_STOP, "R9 still stopped", state_o, S_STOP);
        wake_pin = 1'b1;
        step(3);
        chk(state_o == S_WARM, "R9 rise releases", state_o, S_WARM);
        chk(cfg_rdata[6] == 1'b1, "R9 rise promotes mode", cfg_rdata[6], 1);
        finish_warm();
        wr_cfg(8'h00);
        chk(cfg_rdata[6] == 1'b0, "R9 edge mode immediate", cfg_rdata[6], 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule